// File: doc/BRIEF.md
# Repairable Return Address Stack

This block is a small circular stack of return addresses for speculative call and return prediction. A hardware thread has its own instance. When fetch predicts a call, the caller pushes the address the call will return to. When fetch predicts a return, the caller first reads the top entry and its slot index as the predicted target. It then pops.

Speculation can be wrong, so the stack can be repaired. A squashed call is undone with a plain pop of the slot it pushed. A squashed return is undone with a restore. Before the pop, the controller saves the index and address that the return read. On restore it hands that pair back, the pair becomes the top again, and the slot holds its old address. The stack does not decide when any of these operations happen. That decision belongs to the prediction controller that drives it.

When the stack is full, the pointer wraps and the oldest entry is overwritten. A live-entry count shows how many entries are still valid.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is held, and right after it, the top index is 0, the top address is 0 and the live count is 0. Every slot reads 0 until it is written.
- R2: A push alone moves the top index up by one, modulo the depth. On the next cycle the top address equals the pushed address. The live count goes up by one.
- R3: A pop alone moves the top index down by one, modulo the depth. The live count goes down by one. The top address is the entry that was below the popped one.
- R4: After more pushes than the depth, the index wraps past the last slot to slot 0. The live count stays at the depth. The slot that is reused holds the newest address, and the oldest address is lost.
- R5: A pop on an empty stack (live count 0) leaves the count at 0, but the index still moves down by one, modulo the depth.
- R6: A restore makes the given index the top and writes the given address into that slot. The live count does not change.
- R7: A restore takes priority over a push or a pop in the same cycle. The result is exactly that of the restore alone.
- R8: A push and a pop together, without a restore, overwrite the top slot with the pushed address. The index and the live count do not change.
- R9: Entries below the top are not disturbed by pushes, pops or restores aimed at other slots, so pops return addresses in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request (call) |
| pop_i | input | 1 | Pop request (return or undo of a call) |
| push_addr_i | input | ADDR_W | Address to push |
| restore_i | input | 1 | Restore request |
| restore_idx_i | input | IDX_W | Saved index to make the top |
| restore_addr_i | input | ADDR_W | Saved address to write back into that slot |
| top_addr_o | output | ADDR_W | Address in the top slot (combinational) |
| top_idx_o | output | IDX_W | Top index |
| count_o | output | CNT_W | Live entry count, 0 to DEPTH |

## Verification
The bench targets these corner cases:
- Wrap-around on overflow. A design with a wrong modulo would stick at the last slot or jump to the wrong one.
- Count saturation at both ends. A design with a bad saturation rule would roll the count over to 0 or up to 31, or would freeze the index on an empty pop.
- Priority when push, pop and restore arrive together. Getting this wrong would leave the index one slot off, or would write the push address where the restored one belongs.
- Restore at every slot index. This sweep exposes a decode error in the entry array.
- Simultaneous push and pop. A design that treats it as a push would move the index.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_PUSH,
      OP_POP,
      OP_SWAP,
      OP_RESTORE
   } ras_op_e;

   function automatic ras_op_e ras_decode(input logic push, input logic pop,
                                          input logic restore);
      if (restore)           return OP_RESTORE;
      else if (push && pop)  return OP_SWAP;
      else if (push)         return OP_PUSH;
      else if (pop)          return OP_POP;
      else                   return OP_IDLE;
   endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
   parameter int DEPTH = 16,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             restore,
   input  logic [IDX_W-1:0] restore_idx,
   output logic [IDX_W-1:0] ptr,
   output logic [CNT_W-1:0] count,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             wr_from_restore
);
   import ras_pkg::*;

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   ras_op_e          op;
   logic [IDX_W-1:0] ptr_inc, ptr_dec, ptr_nxt;
   logic [CNT_W-1:0] cnt_nxt;

   assign op      = ras_decode(push, pop, restore);
   assign ptr_inc = ptr + 1'b1;
   assign ptr_dec = ptr - 1'b1;

   always_comb begin
      ptr_nxt         = ptr;
      cnt_nxt         = count;
      wr_en           = 1'b0;
      wr_idx          = ptr;
      wr_from_restore = 1'b0;
      unique case (op)
         OP_RESTORE: begin
            ptr_nxt         = restore_idx;
            wr_en           = 1'b1;
            wr_idx          = restore_idx;
            wr_from_restore = 1'b1;
         end
         OP_SWAP: begin
            wr_en  = 1'b1;
            wr_idx = ptr;
         end
         OP_PUSH: begin
            ptr_nxt = ptr_inc;
            wr_en   = 1'b1;
            wr_idx  = ptr_inc;
            if (count != CNT_FULL) cnt_nxt = count + 1'b1;
         end
         OP_POP: begin
            ptr_nxt = ptr_dec;
            if (count != '0) cnt_nxt = count - 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         count <= '0;
      end else begin
         ptr   <= ptr_nxt;
         count <= cnt_nxt;
      end
   end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
   parameter int ADDR_W         = 32,
   parameter int DEPTH          = 16,
   parameter int IDX_W          = $clog2(DEPTH),
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data
);

   logic [DEPTH-1:0][ADDR_W-1:0] slots;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic              hit;
      logic [ADDR_W-1:0] q;
      assign hit = wr_en && (wr_idx == IDX_W'(g));

      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) q <= wr_data;
         end
      end

      assign slots[g] = q;
   end

   assign rd_data = slots[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
   parameter int ADDR_W         = 32,
   parameter int DEPTH          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   parameter int IDX_W          = $clog2(DEPTH),
   parameter int CNT_W          = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic              restore_i,
   input  logic [IDX_W-1:0]  restore_idx_i,
   input  logic [ADDR_W-1:0] restore_addr_i,
   output logic [ADDR_W-1:0] top_addr_o,
   output logic [IDX_W-1:0]  top_idx_o,
   output logic [CNT_W-1:0]  count_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ret_addr_stack: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_width
      $error("ret_addr_stack: ADDR_W must be positive");
   end

   logic             wr_en, wr_from_restore;
   logic [IDX_W-1:0] wr_idx;
   logic [ADDR_W-1:0] wr_data;

   ras_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .push            (push_i),
      .pop             (pop_i),
      .restore         (restore_i),
      .restore_idx     (restore_idx_i),
      .ptr             (top_idx_o),
      .count           (count_o),
      .wr_en           (wr_en),
      .wr_idx          (wr_idx),
      .wr_from_restore (wr_from_restore)
   );

   assign wr_data = wr_from_restore ? restore_addr_i : push_addr_i;

   ras_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
               .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (top_idx_o),
      .rd_data (top_addr_o)
   );

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16,
   parameter int IDX_W  = $clog2(DEPTH),
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              pop_i,
   input logic [ADDR_W-1:0] push_addr_i,
   input logic              restore_i,
   input logic [IDX_W-1:0]  restore_idx_i,
   input logic [ADDR_W-1:0] restore_addr_i,
   input logic [ADDR_W-1:0] top_addr_o,
   input logic [IDX_W-1:0]  top_idx_o,
   input logic [CNT_W-1:0]  count_o
);

   // R2
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !restore_i) |=>
         (top_idx_o == IDX_W'($past(top_idx_o) + 1'b1)) &&
         (top_addr_o == $past(push_addr_i)));

   // R3
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !restore_i) |=>
         (top_idx_o == IDX_W'($past(top_idx_o) - 1'b1)));

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CNT_W'(DEPTH));

   // R5
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !restore_i && count_o == '0) |=> (count_o == '0));

   // R6
   restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_i |=> (top_idx_o == $past(restore_idx_i)) &&
                    (top_addr_o == $past(restore_addr_i)) &&
                    (count_o == $past(count_o)));

   // R8
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !restore_i) |=>
         (top_idx_o == $past(top_idx_o)) && (count_o == $past(count_o)) &&
         (top_addr_o == $past(push_addr_i)));

endmodule

bind ret_addr_stack ras_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                              .CNT_W(CNT_W)) u_ras_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .push_i         (push_i),
   .pop_i          (pop_i),
   .push_addr_i    (push_addr_i),
   .restore_i      (restore_i),
   .restore_idx_i  (restore_idx_i),
   .restore_addr_i (restore_addr_i),
   .top_addr_o     (top_addr_o),
   .top_idx_o      (top_idx_o),
   .count_o        (count_o)
);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int D  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 1'b0, pop_i = 1'b0, restore_i = 1'b0;
   logic [AW-1:0] push_addr_i = '0, restore_addr_i = '0;
   logic [3:0]    restore_idx_i = '0;
   logic [AW-1:0] top_addr_o;
   logic [3:0]    top_idx_o;
   logic [4:0]    count_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [AW-1:0] m_mem [D];
   int m_ptr = 0;
   int m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ret_addr_stack i_ret_addr_stack (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .push_addr_i(push_addr_i), .restore_i(restore_i),
      .restore_idx_i(restore_idx_i), .restore_addr_i(restore_addr_i),
      .top_addr_o(top_addr_o), .top_idx_o(top_idx_o), .count_o(count_o)
   );

   task automatic check(input string tag);
      checks++;
      if (top_idx_o !== 4'(m_ptr) || top_addr_o !== m_mem[m_ptr] ||
          count_o !== 5'(m_cnt)) begin
         errors++;
         $display("FAIL %s: idx=%0d addr=%h cnt=%0d, expected idx=%0d addr=%h cnt=%0d",
                  tag, top_idx_o, top_addr_o, count_o, m_ptr, m_mem[m_ptr], m_cnt);
      end
   endtask

   task automatic step(input bit pu, input bit po, input bit rs,
                       input logic [AW-1:0] pa, input int ri,
                       input logic [AW-1:0] ra, input string tag);
      push_i = pu; pop_i = po; restore_i = rs;
      push_addr_i = pa; restore_idx_i = 4'(ri); restore_addr_i = ra;
      @(posedge clk);
      if (rs) begin
         m_ptr = ri; m_mem[ri] = ra;
      end else if (pu && po) begin
         m_mem[m_ptr] = pa;
      end else if (pu) begin
         m_ptr = (m_ptr + 1) % D; m_mem[m_ptr] = pa;
         m_cnt = (m_cnt < D) ? m_cnt + 1 : D;
      end else if (po) begin
         m_ptr = (m_ptr + D - 1) % D;
         m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      end
      #(CLK_PERIOD/4);
      push_i = 1'b0; pop_i = 1'b0; restore_i = 1'b0;
      check(tag);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < D; i++) m_mem[i] = '0;
      #(CLK_PERIOD * 2 + 1);
      check("R1 reset held");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset");

      // R2 pushes, R3 pops in LIFO order (R9)
      for (int i = 0; i < 5; i++) step(1, 0, 0, 32'h1000 + 32'(i) * 4, 0, 0, "R2 push");
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, "R3 R9 pop");

      // R8 push+pop replaces the top
      step(1, 1, 0, 32'hCAFE_0001, 0, 0, "R8 swap");

      // R6 undo of a pop: save, pop, restore
      begin
         int            sv_idx;
         logic [AW-1:0] sv_addr;
         sv_idx = int'(top_idx_o); sv_addr = top_addr_o;
         step(0, 1, 0, 0, 0, 0, "R3 pop before repair");
         step(0, 0, 1, 0, sv_idx, sv_addr, "R6 restore");
      end

      // R7 restore wins over push and over pop
      step(1, 0, 1, 32'hDEAD_0000, 7, 32'h7777_0007, "R7 restore over push");
      step(0, 1, 1, 32'hDEAD_0001, 3, 32'h3333_0003, "R7 restore over pop");
      step(1, 1, 1, 32'hDEAD_0002, 9, 32'h9999_0009, "R7 restore over swap");

      // R4 overflow and wrap
      for (int i = 0; i < D + 5; i++)
         step(1, 0, 0, 32'h5000_0000 + 32'(i), 0, 0, "R4 wrap push");
      for (int i = 0; i < D; i++) step(0, 1, 0, 0, 0, 0, "R4 R9 drain");

      // R5 pops on an empty stack
      for (int i = 0; i < D + 3; i++) step(0, 1, 0, 0, 0, 0, "R5 empty pop");

      // R6 sweep of every restore index
      for (int i = 0; i < D; i++)
         step(0, 0, 1, 0, i, 32'hA000_0000 + 32'(i) * 32'h111, "R6 restore sweep");
      // R9 entries below stay intact after the sweep
      for (int i = 0; i < D; i++) step(0, 1, 0, 0, 0, 0, "R9 read back");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule